// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block decides, once per clock, whether a 32-bit soft processor enters a handler, and which one. Four kinds of event can ask for entry: an external interrupt, a debug break, a hardware exception and a memory-translation fault. Unaligned data accesses form a second source of hardware exceptions. The block samples the processor's current PC, its machine status word, the instruction-state flags, the pending branch target and the vector base. From these it produces a complete set of state updates: the new PC, the new status word, one link-register write, and the syndrome, branch-target and fault-address register writes. It also raises a pulse that tells the core to drop its load reservation and clear its instruction flags.

All updates for one entry come out together, one clock after the request is sampled, as a single-cycle pulse. The surrounding core applies them to its architectural registers. The status word layout, the vector offsets, the syndrome fields and whether hardware exceptions are built in are all parameters.

Instruction-state flags on `iflags_i`: bit 0 marks a delay slot, bit 1 marks an instruction after an immediate prefix, and bit 2 marks a delay slot whose branch used an immediate prefix. Default status bit positions: interrupt enable 1, break in progress 3, exception in progress 9, user mode 11 (saved copy 12), virtual memory 13 (saved copy 14). The cause codes are 0 interrupt, 1 break, 2 hardware exception and 3 memory fault. The vectors default to base + 0x10, + 0x18 and + 0x20.

Top module: `exc_entry`

## Requirements
- R1: An interrupt is taken only when the request is high, the interrupt-enable bit is 1, the exception-in-progress and break-in-progress bits are both 0, and iflags bits 0 and 1 are both 0. Otherwise the interrupt request is ignored and take_o stays 0.
- R2: Interrupt entry clears interrupt-enable, writes the PC to link register 14 and jumps to vector base + 0x10.
- R3: Break entry sets break-in-progress, writes the PC to link register 16 and jumps to vector base + 0x18.
- R4: Hardware-exception entry sets exception-in-progress, writes PC+4 to link register 17 and jumps to vector base + 0x20.
- R5: Memory-fault entry writes PC-8 to register 17 when iflags bits 0 and 2 are both set. It writes PC-4 when bit 0 or bit 1 is set, and otherwise it writes the PC. It sets exception-in-progress and jumps to vector base + 0x20.
- R6: On either kind of exception, the syndrome is written with its bit 12 equal to iflags bit 0. The branch-target register is written with the pending branch target only when iflags bit 0 is set. A plain hardware exception puts its 5-bit code in syndrome bits 4:0. A memory fault does the same with its own code and also loads the fault-address register.
- R7: Every entry copies the user-mode and virtual-memory bits into the bit above each one, and then clears both of them.
- R8: Every entry, and nothing else, raises clr_o together with take_o for exactly one cycle, one clock after the request. After reset all pulses are 0.
- R9: When hardware exceptions are configured out, a hardware-exception or unaligned request is ignored. No entry and no register write results. A break requested in the same cycle is still taken.
- R10: An unaligned access enters as a hardware exception. The syndrome holds code 1 in bits 4:0 and the 7-bit syndrome input in bits 11:5, and the fault-address register is loaded with the faulting address.
- R11: Simultaneous requests are served in this order: memory fault, hardware exception, break, interrupt.
- R12: A memory-fault request while exception-in-progress is set, when the last entry taken was a memory fault, raises err_o and causes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pc_i | input | 32 | Current PC |
| msr_i | input | 32 | Current status word |
| iflags_i | input | 3 | {branch-immediate, immediate prefix, delay slot} |
| btarget_i | input | 32 | Pending branch target |
| vec_base_i | input | 32 | Vector base address |
| fault_addr_i | input | 32 | Faulting data address |
| irq_req_i | input | 1 | External interrupt request |
| brk_req_i | input | 1 | Break request |
| hwe_req_i | input | 1 | Hardware exception request |
| hwe_code_i | input | 5 | Hardware exception code |
| unal_req_i | input | 1 | Unaligned access request |
| unal_syn_i | input | 7 | Unaligned access syndrome bits |
| mf_req_i | input | 1 | Memory fault request |
| mf_code_i | input | 5 | Memory fault code |
| take_o | output | 1 | Entry pulse |
| cause_o | output | 2 | Entry cause |
| pc_o | output | 32 | New PC |
| msr_o | output | 32 | New status word |
| lr_we_o | output | 1 | Link register write enable |
| lr_idx_o | output | 5 | Link register number |
| lr_data_o | output | 32 | Link register value |
| esr_we_o | output | 1 | Syndrome write enable |
| esr_o | output | 16 | Syndrome value |
| btr_we_o | output | 1 | Branch-target register write enable |
| btr_o | output | 32 | Branch-target value |
| ear_we_o | output | 1 | Fault-address write enable |
| ear_o | output | 32 | Fault-address value |
| clr_o | output | 1 | Drop reservation and clear instruction flags |
| err_o | output | 1 | Recursive memory fault |

## Verification
A wrong arbitration result shows up one clock after the request, as a wrong cause_o, link register number or vector. A fault in the return-address arithmetic appears at the same time on lr_data_o, off by 4 or 8. The only state kept across cycles is the memory of the last entry's cause. If it is wrong, the error is visible only on the next memory-fault request made with exception-in-progress set: err_o is missing or spurious, and an entry happens that should not, or the reverse.

// File: rtl/exc_pkg.sv
package exc_pkg;
   typedef enum logic [1:0] {
      CAUSE_IRQ = 2'd0,
      CAUSE_BRK = 2'd1,
      CAUSE_HWE = 2'd2,
      CAUSE_MF  = 2'd3
   } cause_e;

   localparam int FLAG_W    = 3;
   localparam int FLAG_DS   = 0;
   localparam int FLAG_IMM  = 1;
   localparam int FLAG_BIMM = 2;
   localparam int LRIDX_W   = 5;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_pkg::*;
#(
   parameter bit EXC_EN = 1'b1
) (
   input  logic   irq_req,
   input  logic   irq_ok,
   input  logic   brk_req,
   input  logic   hwe_req,
   input  logic   unal_req,
   input  logic   mf_req,
   input  logic   mf_recursive,
   output logic   take,
   output cause_e cause,
   output logic   is_unal,
   output logic   err
);
   logic hwe_any;

   generate
      if (EXC_EN) begin : g_exc_on
         assign hwe_any = hwe_req | unal_req;
      end else begin : g_exc_off
         // requests are accepted on the port but never reach the selector
         assign hwe_any = 1'b0 & (hwe_req | unal_req);
      end
   endgenerate

   always_comb begin
      take    = 1'b0;
      cause   = CAUSE_IRQ;
      is_unal = 1'b0;
      err     = 1'b0;
      if (mf_req) begin
         if (mf_recursive) begin
            err = 1'b1;
         end else begin
            take  = 1'b1;
            cause = CAUSE_MF;
         end
      end else if (hwe_any) begin
         take    = 1'b1;
         cause   = CAUSE_HWE;
         is_unal = unal_req;
      end else if (brk_req) begin
         take  = 1'b1;
         cause = CAUSE_BRK;
      end else if (irq_req && irq_ok) begin
         take  = 1'b1;
         cause = CAUSE_IRQ;
      end
   end
endmodule

// File: rtl/exc_target.sv
module exc_target
   import exc_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int IRQ_OFF = 'h10,
   parameter int BRK_OFF = 'h18,
   parameter int EXC_OFF = 'h20,
   parameter int LR_IRQ  = 14,
   parameter int LR_BRK  = 16,
   parameter int LR_EXC  = 17
) (
   input  logic [XLEN-1:0]    pc,
   input  logic [XLEN-1:0]    vec_base,
   input  logic [FLAG_W-1:0]  flags,
   input  cause_e             cause,
   output logic [XLEN-1:0]    new_pc,
   output logic [LRIDX_W-1:0] lr_idx,
   output logic [XLEN-1:0]    lr_data
);
   localparam logic [XLEN-1:0] STEP = XLEN'(4);

   logic [XLEN-1:0] mf_ret;

   // return point for a translation fault: re-run the branch or prefix
   always_comb begin
      if (flags[FLAG_DS] && flags[FLAG_BIMM]) begin
         mf_ret = pc - (STEP << 1);
      end else if (flags[FLAG_DS] || flags[FLAG_IMM]) begin
         mf_ret = pc - STEP;
      end else begin
         mf_ret = pc;
      end
   end

   always_comb begin
      unique case (cause)
         CAUSE_IRQ: begin
            new_pc  = vec_base + XLEN'(IRQ_OFF);
            lr_idx  = LRIDX_W'(LR_IRQ);
            lr_data = pc;
         end
         CAUSE_BRK: begin
            new_pc  = vec_base + XLEN'(BRK_OFF);
            lr_idx  = LRIDX_W'(LR_BRK);
            lr_data = pc;
         end
         CAUSE_HWE: begin
            new_pc  = vec_base + XLEN'(EXC_OFF);
            lr_idx  = LRIDX_W'(LR_EXC);
            lr_data = pc + STEP;
         end
         default: begin
            new_pc  = vec_base + XLEN'(EXC_OFF);
            lr_idx  = LRIDX_W'(LR_EXC);
            lr_data = mf_ret;
         end
      endcase
   end
endmodule

// File: rtl/exc_status.sv
module exc_status
   import exc_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int IE_BIT  = 1,
   parameter int BIP_BIT = 3,
   parameter int EIP_BIT = 9,
   parameter int UM_BIT  = 11,
   parameter int VM_BIT  = 13
) (
   input  logic [XLEN-1:0] msr_in,
   input  logic            ds,
   input  logic            imm,
   input  cause_e          cause,
   output logic            irq_ok,
   output logic [XLEN-1:0] msr_out
);
   assign irq_ok = msr_in[IE_BIT] & ~msr_in[EIP_BIT] & ~msr_in[BIP_BIT]
                 & ~ds & ~imm;

   always_comb begin
      msr_out = msr_in;
      unique case (cause)
         CAUSE_IRQ: msr_out[IE_BIT]  = 1'b0;
         CAUSE_BRK: msr_out[BIP_BIT] = 1'b1;
         default:   msr_out[EIP_BIT] = 1'b1;
      endcase
      // one-deep mode stack: live bits move up one place, then drop
      msr_out[UM_BIT+1] = msr_in[UM_BIT];
      msr_out[VM_BIT+1] = msr_in[VM_BIT];
      msr_out[UM_BIT]   = 1'b0;
      msr_out[VM_BIT]   = 1'b0;
   end
endmodule

// File: rtl/exc_syndrome.sv
module exc_syndrome
   import exc_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int ESR_W     = 16,
   parameter int CODE_W    = 5,
   parameter int SYN_W     = 7,
   parameter int SYN_LSB   = 5,
   parameter int DS_BIT    = 12,
   parameter int UNAL_CODE = 1
) (
   input  cause_e            cause,
   input  logic              is_unal,
   input  logic              ds,
   input  logic [XLEN-1:0]   btarget,
   input  logic [XLEN-1:0]   fault_addr,
   input  logic [CODE_W-1:0] hwe_code,
   input  logic [CODE_W-1:0] mf_code,
   input  logic [SYN_W-1:0]  syn,
   output logic              esr_we,
   output logic [ESR_W-1:0]  esr,
   output logic              btr_we,
   output logic [XLEN-1:0]   btr,
   output logic              ear_we,
   output logic [XLEN-1:0]   ear
);
   logic is_exc;

   assign is_exc = (cause == CAUSE_HWE) || (cause == CAUSE_MF);

   always_comb begin
      esr = '0;
      if (is_unal) begin
         esr[CODE_W-1:0]       = CODE_W'(UNAL_CODE);
         esr[SYN_LSB +: SYN_W] = syn;
      end else if (cause == CAUSE_MF) begin
         esr[CODE_W-1:0] = mf_code;
      end else begin
         esr[CODE_W-1:0] = hwe_code;
      end
      esr[DS_BIT] = ds;
   end

   assign esr_we = is_exc;
   assign btr_we = is_exc & ds;
   assign btr    = btarget;
   assign ear_we = (cause == CAUSE_MF) | is_unal;
   assign ear    = fault_addr;
endmodule

// File: rtl/exc_entry.sv
module exc_entry
   import exc_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter bit EXC_EN    = 1'b1,
   parameter int IE_BIT    = 1,
   parameter int BIP_BIT   = 3,
   parameter int EIP_BIT   = 9,
   parameter int UM_BIT    = 11,
   parameter int VM_BIT    = 13,
   parameter int IRQ_OFF   = 'h10,
   parameter int BRK_OFF   = 'h18,
   parameter int EXC_OFF   = 'h20,
   parameter int ESR_W     = 16,
   parameter int CODE_W    = 5,
   parameter int SYN_W     = 7,
   parameter int SYN_LSB   = 5,
   parameter int DS_BIT    = 12,
   parameter int UNAL_CODE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [XLEN-1:0]   pc_i,
   input  logic [XLEN-1:0]   msr_i,
   input  logic [2:0]        iflags_i,
   input  logic [XLEN-1:0]   btarget_i,
   input  logic [XLEN-1:0]   vec_base_i,
   input  logic [XLEN-1:0]   fault_addr_i,
   input  logic              irq_req_i,
   input  logic              brk_req_i,
   input  logic              hwe_req_i,
   input  logic [CODE_W-1:0] hwe_code_i,
   input  logic              unal_req_i,
   input  logic [SYN_W-1:0]  unal_syn_i,
   input  logic              mf_req_i,
   input  logic [CODE_W-1:0] mf_code_i,
   output logic              take_o,
   output logic [1:0]        cause_o,
   output logic [XLEN-1:0]   pc_o,
   output logic [XLEN-1:0]   msr_o,
   output logic              lr_we_o,
   output logic [4:0]        lr_idx_o,
   output logic [XLEN-1:0]   lr_data_o,
   output logic              esr_we_o,
   output logic [ESR_W-1:0]  esr_o,
   output logic              btr_we_o,
   output logic [XLEN-1:0]   btr_o,
   output logic              ear_we_o,
   output logic [XLEN-1:0]   ear_o,
   output logic              clr_o,
   output logic              err_o
);
   localparam int TOP_BIT = (UM_BIT > VM_BIT) ? UM_BIT : VM_BIT;

   generate
      if (TOP_BIT + 1 >= XLEN) begin : g_bad_mode
         $error("mode bits need a saved copy inside the status word");
      end
      if (UM_BIT == VM_BIT || UM_BIT + 1 == VM_BIT || VM_BIT + 1 == UM_BIT) begin : g_bad_stack
         $error("mode bits and their saved copies must not overlap");
      end
      if (SYN_LSB < CODE_W || SYN_LSB + SYN_W > DS_BIT || DS_BIT >= ESR_W) begin : g_bad_esr
         $error("syndrome fields overlap or do not fit");
      end
      if (XLEN < 8) begin : g_bad_xlen
         $error("word too narrow");
      end
   endgenerate

   // ---------------- combinational entry decision ----------------
   logic            irq_ok, take_c, is_unal_c, err_c, mf_rec_c;
   cause_e          cause_c;
   logic [XLEN-1:0] npc_c, lrd_c, msr_c, btr_c, ear_c;
   logic [4:0]      lri_c;
   logic            esr_we_c, btr_we_c, ear_we_c;
   logic [ESR_W-1:0] esr_c;
   logic            last_mf_q;

   assign mf_rec_c = last_mf_q & msr_i[EIP_BIT];

   exc_status #(
      .XLEN(XLEN), .IE_BIT(IE_BIT), .BIP_BIT(BIP_BIT), .EIP_BIT(EIP_BIT),
      .UM_BIT(UM_BIT), .VM_BIT(VM_BIT)
   ) u_status (
      .msr_in (msr_i),
      .ds     (iflags_i[FLAG_DS]),
      .imm    (iflags_i[FLAG_IMM]),
      .cause  (cause_c),
      .irq_ok (irq_ok),
      .msr_out(msr_c)
   );

   exc_arbiter #(.EXC_EN(EXC_EN)) u_arb (
      .irq_req     (irq_req_i),
      .irq_ok      (irq_ok),
      .brk_req     (brk_req_i),
      .hwe_req     (hwe_req_i),
      .unal_req    (unal_req_i),
      .mf_req      (mf_req_i),
      .mf_recursive(mf_rec_c),
      .take        (take_c),
      .cause       (cause_c),
      .is_unal     (is_unal_c),
      .err         (err_c)
   );

   exc_target #(
      .XLEN(XLEN), .IRQ_OFF(IRQ_OFF), .BRK_OFF(BRK_OFF), .EXC_OFF(EXC_OFF)
   ) u_target (
      .pc      (pc_i),
      .vec_base(vec_base_i),
      .flags   (iflags_i),
      .cause   (cause_c),
      .new_pc  (npc_c),
      .lr_idx  (lri_c),
      .lr_data (lrd_c)
   );

   exc_syndrome #(
      .XLEN(XLEN), .ESR_W(ESR_W), .CODE_W(CODE_W), .SYN_W(SYN_W),
      .SYN_LSB(SYN_LSB), .DS_BIT(DS_BIT), .UNAL_CODE(UNAL_CODE)
   ) u_syn (
      .cause     (cause_c),
      .is_unal   (is_unal_c),
      .ds        (iflags_i[FLAG_DS]),
      .btarget   (btarget_i),
      .fault_addr(fault_addr_i),
      .hwe_code  (hwe_code_i),
      .mf_code   (mf_code_i),
      .syn       (unal_syn_i),
      .esr_we    (esr_we_c),
      .esr       (esr_c),
      .btr_we    (btr_we_c),
      .btr       (btr_c),
      .ear_we    (ear_we_c),
      .ear       (ear_c)
   );

   // ---------------- registered update bundle ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_o    <= 1'b0;
         clr_o     <= 1'b0;
         err_o     <= 1'b0;
         lr_we_o   <= 1'b0;
         esr_we_o  <= 1'b0;
         btr_we_o  <= 1'b0;
         ear_we_o  <= 1'b0;
         last_mf_q <= 1'b0;
      end else begin
         take_o   <= take_c;
         clr_o    <= take_c;
         err_o    <= err_c;
         lr_we_o  <= take_c;
         esr_we_o <= take_c & esr_we_c;
         btr_we_o <= take_c & btr_we_c;
         ear_we_o <= take_c & ear_we_c;
         if (take_c) begin
            last_mf_q <= (cause_c == CAUSE_MF);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_o   <= 2'd0;
         pc_o      <= '0;
         msr_o     <= '0;
         lr_idx_o  <= '0;
         lr_data_o <= '0;
         esr_o     <= '0;
         btr_o     <= '0;
         ear_o     <= '0;
      end else if (take_c) begin
         cause_o   <= cause_c;
         pc_o      <= npc_c;
         msr_o     <= msr_c;
         lr_idx_o  <= lri_c;
         lr_data_o <= lrd_c;
         esr_o     <= esr_c;
         btr_o     <= btr_c;
         ear_o     <= ear_c;
      end
   end

   // ---------------- assertions ----------------
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && cause_o == 2'd0) |-> ($past(msr_i[IE_BIT]) && !$past(msr_i[EIP_BIT])
                                       && !$past(msr_i[BIP_BIT]) && !$past(iflags_i[0])
                                       && !$past(iflags_i[1]))); // R1

   AST_MODE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (msr_o[UM_BIT+1] == $past(msr_i[UM_BIT]) && !msr_o[UM_BIT]
                  && msr_o[VM_BIT+1] == $past(msr_i[VM_BIT]) && !msr_o[VM_BIT])); // R7

   AST_FAULT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && $past(mf_req_i)) |-> cause_o == 2'd3); // R11

   AST_RECURSE_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!take_o && $past(mf_req_i) && $past(msr_i[EIP_BIT]))); // R12

   AST_BTR_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      btr_we_o |-> ($past(iflags_i[0]) && take_o)); // R6

   generate
      if (!EXC_EN) begin : g_chk_noexc
         AST_NO_HWE: assert property (@(posedge clk) disable iff (!rst_n)
            take_o |-> cause_o != 2'd2); // R9
      end
   endgenerate
endmodule

// File: tb/exc_entry_test.sv
`timescale 1ns/1ps
module exc_entry_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc_i = '0, msr_i = '0, btarget_i = '0, vec_base_i = 32'h1000, fault_addr_i = '0;
   logic [2:0]  iflags_i = '0;
   logic        irq_req_i = 0, brk_req_i = 0, hwe_req_i = 0, unal_req_i = 0, mf_req_i = 0;
   logic [4:0]  hwe_code_i = '0, mf_code_i = '0;
   logic [6:0]  unal_syn_i = '0;

   logic        take_o, lr_we_o, esr_we_o, btr_we_o, ear_we_o, clr_o, err_o;
   logic [1:0]  cause_o;
   logic [31:0] pc_o, msr_o, lr_data_o, btr_o, ear_o;
   logic [4:0]  lr_idx_o;
   logic [15:0] esr_o;

   logic        n_take, n_lr_we, n_esr_we, n_btr_we, n_ear_we, n_clr, n_err;
   logic [1:0]  n_cause;
   logic [31:0] n_pc, n_msr, n_lr_data, n_btr, n_ear;
   logic [4:0]  n_lr_idx;
   logic [15:0] n_esr;

   always #2 clk = ~clk;

   exc_entry uut (
      .clk, .rst_n, .pc_i, .msr_i, .iflags_i, .btarget_i, .vec_base_i, .fault_addr_i,
      .irq_req_i, .brk_req_i, .hwe_req_i, .hwe_code_i, .unal_req_i, .unal_syn_i,
      .mf_req_i, .mf_code_i, .take_o, .cause_o, .pc_o, .msr_o, .lr_we_o, .lr_idx_o,
      .lr_data_o, .esr_we_o, .esr_o, .btr_we_o, .btr_o, .ear_we_o, .ear_o, .clr_o, .err_o);

   exc_entry #(.EXC_EN(1'b0)) uut_noexc (
      .clk, .rst_n, .pc_i, .msr_i, .iflags_i, .btarget_i, .vec_base_i, .fault_addr_i,
      .irq_req_i, .brk_req_i, .hwe_req_i, .hwe_code_i, .unal_req_i, .unal_syn_i,
      .mf_req_i, .mf_code_i, .take_o(n_take), .cause_o(n_cause), .pc_o(n_pc),
      .msr_o(n_msr), .lr_we_o(n_lr_we), .lr_idx_o(n_lr_idx), .lr_data_o(n_lr_data),
      .esr_we_o(n_esr_we), .esr_o(n_esr), .btr_we_o(n_btr_we), .btr_o(n_btr),
      .ear_we_o(n_ear_we), .ear_o(n_ear), .clr_o(n_clr), .err_o(n_err));

   int checks = 0, fails = 0;
   bit done = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   typedef struct packed {
      logic [3:0]  req;      // {mf, hwe, brk, irq}
      logic [2:0]  flags;
      logic [31:0] msr;
      logic [31:0] pc;
      logic        e_take;
      logic [1:0]  e_cause;
      logic [31:0] e_pc;
      logic [4:0]  e_idx;
      logic [31:0] e_lr;
      logic [31:0] e_msr;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VT [NV] = '{
      '{4'b0001, 3'b000, 32'h2802, 32'h100, 1'b1, 2'd0, 32'h1010, 5'd14, 32'h100, 32'h5000}, // R2 R7
      '{4'b0001, 3'b000, 32'h0202, 32'h110, 1'b0, 2'd0, 32'h0, 5'd0, 32'h0, 32'h0},       // R1 EIP
      '{4'b0001, 3'b001, 32'h0002, 32'h120, 1'b0, 2'd0, 32'h0, 5'd0, 32'h0, 32'h0},       // R1 ds
      '{4'b0001, 3'b010, 32'h0002, 32'h130, 1'b0, 2'd0, 32'h0, 5'd0, 32'h0, 32'h0},       // R1 imm
      '{4'b0001, 3'b000, 32'h0000, 32'h140, 1'b0, 2'd0, 32'h0, 5'd0, 32'h0, 32'h0},       // R1 IE off
      '{4'b0001, 3'b000, 32'h000A, 32'h150, 1'b0, 2'd0, 32'h0, 5'd0, 32'h0, 32'h0},       // R1 BIP
      '{4'b0010, 3'b000, 32'h0800, 32'h200, 1'b1, 2'd1, 32'h1018, 5'd16, 32'h200, 32'h1008}, // R3
      '{4'b0100, 3'b000, 32'h2002, 32'h300, 1'b1, 2'd2, 32'h1020, 5'd17, 32'h304, 32'h4202}, // R4
      '{4'b1000, 3'b101, 32'h0000, 32'h400, 1'b1, 2'd3, 32'h1020, 5'd17, 32'h3F8, 32'h0200}, // R5
      '{4'b1000, 3'b010, 32'h0000, 32'h500, 1'b1, 2'd3, 32'h1020, 5'd17, 32'h4FC, 32'h0200}, // R5
      '{4'b1000, 3'b001, 32'h0000, 32'h600, 1'b1, 2'd3, 32'h1020, 5'd17, 32'h5FC, 32'h0200}, // R5
      '{4'b1000, 3'b000, 32'h0000, 32'h700, 1'b1, 2'd3, 32'h1020, 5'd17, 32'h700, 32'h0200}, // R5
      '{4'b1111, 3'b000, 32'h0002, 32'h800, 1'b1, 2'd3, 32'h1020, 5'd17, 32'h800, 32'h0202}, // R11
      '{4'b0111, 3'b000, 32'h0002, 32'h900, 1'b1, 2'd2, 32'h1020, 5'd17, 32'h904, 32'h0202}, // R11
      '{4'b0011, 3'b000, 32'h0002, 32'hA00, 1'b1, 2'd1, 32'h1018, 5'd16, 32'hA00, 32'h000A}, // R11
      '{4'b0010, 3'b000, 32'h5000, 32'hB00, 1'b1, 2'd1, 32'h1018, 5'd16, 32'hB00, 32'h0008}  // R7
   };

   task automatic clear_req();
      irq_req_i = 0; brk_req_i = 0; hwe_req_i = 0; unal_req_i = 0; mf_req_i = 0;
   endtask

   // inputs change at negedge; registered result is checked 1 ns after the next posedge
   task automatic strobe();
      @(posedge clk);
      #1;
   endtask

   task automatic idle_check();
      @(negedge clk);
      clear_req();
      iflags_i = '0;
      strobe();
      chk("R8 idle take", {31'b0, take_o}, 32'd0);
   endtask

   initial begin
      clear_req();
      repeat (3) @(posedge clk);
      #1;
      chk("R8 reset take", {31'b0, take_o}, 32'd0);
      chk("R8 reset clr", {31'b0, clr_o}, 32'd0);
      chk("R12 reset err", {31'b0, err_o}, 32'd0);
      chk("R6 reset esr_we", {31'b0, esr_we_o}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {mf_req_i, hwe_req_i, brk_req_i, irq_req_i} = VT[i].req;
         iflags_i = VT[i].flags;
         msr_i    = VT[i].msr;
         pc_i     = VT[i].pc;
         strobe();
         chk($sformatf("R1 R11 v%0d take", i), {31'b0, take_o}, {31'b0, VT[i].e_take});
         chk($sformatf("R8 v%0d clr", i), {31'b0, clr_o}, {31'b0, VT[i].e_take});
         if (VT[i].e_take) begin
            chk($sformatf("R11 v%0d cause", i), {30'b0, cause_o}, {30'b0, VT[i].e_cause});
            chk($sformatf("R2 R3 R4 v%0d pc", i), pc_o, VT[i].e_pc);
            chk($sformatf("R2 R3 R4 v%0d lr_idx", i), {27'b0, lr_idx_o}, {27'b0, VT[i].e_idx});
            chk($sformatf("R5 v%0d lr_data", i), lr_data_o, VT[i].e_lr);
            chk($sformatf("R7 v%0d msr", i), msr_o, VT[i].e_msr);
            chk($sformatf("R8 v%0d lr_we", i), {31'b0, lr_we_o}, 32'd1);
         end else begin
            chk($sformatf("R1 v%0d lr_we", i), {31'b0, lr_we_o}, 32'd0);
         end
         idle_check();
      end

      // R6: memory fault in a delay slot, code in bits 4:0, bit 12 set, BTR and EAR written
      @(negedge clk);
      mf_req_i = 1; iflags_i = 3'b001; msr_i = 0; pc_i = 32'hC00;
      btarget_i = 32'hCAFE0; fault_addr_i = 32'h1234; mf_code_i = 5'h12;
      strobe();
      chk("R6 mf esr_we", {31'b0, esr_we_o}, 32'd1);
      chk("R6 mf esr", {16'b0, esr_o}, 32'h1012);
      chk("R6 mf btr_we", {31'b0, btr_we_o}, 32'd1);
      chk("R6 mf btr", btr_o, 32'hCAFE0);
      chk("R6 mf ear_we", {31'b0, ear_we_o}, 32'd1);
      chk("R6 mf ear", ear_o, 32'h1234);
      chk("R5 mf ds lr", lr_data_o, 32'hBFC);
      idle_check();

      // R6: plain hardware exception outside a delay slot
      @(negedge clk);
      hwe_req_i = 1; hwe_code_i = 5'h07; pc_i = 32'hD00; iflags_i = 3'b000;
      strobe();
      chk("R6 hwe esr", {16'b0, esr_o}, 32'h0007);
      chk("R6 hwe btr_we", {31'b0, btr_we_o}, 32'd0);
      chk("R6 hwe ear_we", {31'b0, ear_we_o}, 32'd0);
      idle_check();

      // R10: unaligned access
      @(negedge clk);
      unal_req_i = 1; unal_syn_i = 7'h15; fault_addr_i = 32'h2003; pc_i = 32'hE00;
      strobe();
      chk("R10 unal cause", {30'b0, cause_o}, 32'd2);
      chk("R10 unal esr", {16'b0, esr_o}, 32'h02A1);
      chk("R10 unal ear_we", {31'b0, ear_we_o}, 32'd1);
      chk("R10 unal ear", ear_o, 32'h2003);
      chk("R10 unal lr", lr_data_o, 32'hE04);
      idle_check();

      // R9: exceptions configured out
      @(negedge clk);
      hwe_req_i = 1; msr_i = 0;
      strobe();
      chk("R9 noexc hwe take", {31'b0, n_take}, 32'd0);
      chk("R9 noexc hwe lr_we", {31'b0, n_lr_we}, 32'd0);
      chk("R9 noexc hwe esr_we", {31'b0, n_esr_we}, 32'd0);
      idle_check();
      @(negedge clk);
      unal_req_i = 1;
      strobe();
      chk("R9 noexc unal take", {31'b0, n_take}, 32'd0);
      chk("R9 noexc unal ear_we", {31'b0, n_ear_we}, 32'd0);
      idle_check();
      @(negedge clk);
      hwe_req_i = 1; brk_req_i = 1; pc_i = 32'hF00;
      strobe();
      chk("R9 noexc brk take", {31'b0, n_take}, 32'd1);
      chk("R9 noexc brk cause", {30'b0, n_cause}, 32'd1);
      chk("R9 noexc brk lr", n_lr_data, 32'hF00);
      idle_check();

      // R12: recursive memory fault
      @(negedge clk);
      mf_req_i = 1; msr_i = 0; pc_i = 32'h1100;
      strobe();
      chk("R12 first mf take", {31'b0, take_o}, 32'd1);
      idle_check();
      @(negedge clk);
      mf_req_i = 1; msr_i = 32'h200;
      strobe();
      chk("R12 recursive err", {31'b0, err_o}, 32'd1);
      chk("R12 recursive take", {31'b0, take_o}, 32'd0);
      idle_check();
      chk("R12 err pulse ends", {31'b0, err_o}, 32'd0);
      @(negedge clk);
      brk_req_i = 1; msr_i = 0;
      strobe();
      chk("R12 brk take", {31'b0, take_o}, 32'd1);
      idle_check();
      @(negedge clk);
      mf_req_i = 1; msr_i = 32'h200;
      strobe();
      chk("R12 after brk err", {31'b0, err_o}, 32'd0);
      chk("R12 after brk take", {31'b0, take_o}, 32'd1);
      idle_check();

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule